// File: doc/BRIEF.md
# Thermal Code to Millidegree Converter

This block turns a 12-bit raw code from an on-die thermal sensor into a signed temperature in millidegrees Celsius. The conversion has two stages. The linear model subtracts a scaled code from a configured offset. The scale is given in tenths. The piecewise model picks its slope and intercept from a fixed table. The choice depends on whether the code lies above a knee value and on which channel produced the sample. In both models, a configured deviation is added to the result after the conversion.

Results leave two cycles after the sample enters. The unit takes one sample per cycle, and the channel index travels with each result. A code of zero means the sensor has not converted yet. Such a sample still produces an output beat, but that beat is flagged as not ready and carries no temperature. The offset, scale, deviation and mode are quasi-static inputs that a surrounding register block holds steady.

Top module: `tconv_top`

## Requirements
- R1: Each accepted sample (in_valid high) produces exactly one out_valid beat two clock edges later, with no dead cycles between back-to-back samples. A cycle without in_valid produces a cycle with out_valid low two edges later.
- R2: When cfg_mode is 0 (linear), out_temp = cfg_offset − trunc(code × cfg_scale / 10). The unsigned product is divided with the remainder discarded.
- R3: cfg_deviation is added after the model's division in both modes. It is never scaled or divided.
- R4: A code of 0 gives out_not_ready = 1 and out_temp = 0 in that beat, in either mode. Any non-zero code gives out_not_ready = 0.
- R5: When cfg_mode is 1 (piecewise) and the code is 0x500 or above, out_temp = trunc(−1191 × code / 10) + 223000 + deviation, on every channel.
- R6: In piecewise mode with the code below 0x500 on channel 0, out_temp = trunc(−1452 × code / 10) + 259000 + deviation. Division truncates toward zero.
- R7: In piecewise mode with the code below 0x500 on any channel other than 0, out_temp = trunc(−1590 × code / 10) + 276000 + deviation.
- R8: out_chan equals the in_chan of the sample that produced the beat.
- R9: While reset is high, and in any cycle with out_valid low, out_temp and out_not_ready are 0.
- R10: In piecewise mode, cfg_offset and cfg_scale have no effect on out_temp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | CH_W (2) | Sensor channel index |
| in_code | input | 12 | Raw sensor code |
| cfg_mode | input | 1 | 0 = linear model, 1 = piecewise model |
| cfg_offset | input | 32 | Signed linear intercept in millidegrees |
| cfg_scale | input | 16 | Linear slope in tenths of a millidegree per code |
| cfg_deviation | input | 32 | Signed correction added after the model |
| out_valid | output | 1 | Result strobe |
| out_chan | output | CH_W (2) | Channel of the result |
| out_temp | output | 32 | Signed temperature in millidegrees |
| out_not_ready | output | 1 | Sample had code 0; no temperature |

## Verification
The bench targets the knee at codes 0x4FF and 0x500 on channel 0 and on a non-zero channel. A design with an off-by-one compare, or one that tests the channel before the threshold, would return the wrong intercept there. Piecewise results are negative before the intercept is added, so codes whose product is not a multiple of ten are used. A floor division would come out one millidegree low on those codes. The deviation is placed where a design that folded it into the divided term would lose nine tenths of it. Zero codes are placed inside back-to-back streams to catch a flag or channel that slips by one beat.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

    localparam int CODE_W  = 12;
    localparam int SCALE_W = 16;
    localparam int TEMP_W  = 32;
    localparam int PROD_W  = CODE_W + SCALE_W;

    // Piecewise model table
    localparam logic [CODE_W-1:0]         PW_KNEE      = 12'h500;
    localparam logic [SCALE_W-1:0]        PW_SLOPE_HI  = 16'd1191;
    localparam logic signed [TEMP_W-1:0]  PW_ICPT_HI   = 32'sd223000;
    localparam logic [SCALE_W-1:0]        PW_SLOPE_LO0 = 16'd1452;
    localparam logic signed [TEMP_W-1:0]  PW_ICPT_LO0  = 32'sd259000;
    localparam logic [SCALE_W-1:0]        PW_SLOPE_LON = 16'd1590;
    localparam logic signed [TEMP_W-1:0]  PW_ICPT_LON  = 32'sd276000;

    typedef enum logic {
        MODE_LINEAR    = 1'b0,
        MODE_PIECEWISE = 1'b1
    } conv_mode_e;

    // temp = icpt - (code * slope) / 10
    typedef struct packed {
        logic signed [TEMP_W-1:0] icpt;
        logic [SCALE_W-1:0]       slope;
    } coef_t;

    // Stage-one register contents (channel travels beside it)
    typedef struct packed {
        logic                     valid;
        logic                     zero;
        logic [PROD_W-1:0]        prod;
        logic signed [TEMP_W-1:0] icpt;
        logic signed [TEMP_W-1:0] dev;
    } stage1_t;

    function automatic coef_t pw_coef(input logic [CODE_W-1:0] code,
                                      input logic chan_is0);
        coef_t c;
        if (code >= PW_KNEE) begin
            c.icpt  = PW_ICPT_HI;
            c.slope = PW_SLOPE_HI;
        end else if (chan_is0) begin
            c.icpt  = PW_ICPT_LO0;
            c.slope = PW_SLOPE_LO0;
        end else begin
            c.icpt  = PW_ICPT_LON;
            c.slope = PW_SLOPE_LON;
        end
        return c;
    endfunction

endpackage

// File: rtl/tconv_coef_sel.sv
module tconv_coef_sel
    import tconv_pkg::*;
(
    input  conv_mode_e                mode,
    input  logic                      chan_is0,
    input  logic [CODE_W-1:0]         code,
    input  logic signed [TEMP_W-1:0]  lin_offset,
    input  logic [SCALE_W-1:0]        lin_scale,
    output coef_t                     coef
);

    always_comb begin
        if (mode == MODE_PIECEWISE) begin
            coef = pw_coef(code, chan_is0);
        end else begin
            coef.icpt  = lin_offset;
            coef.slope = lin_scale;
        end
    end

endmodule

// File: rtl/tconv_mul_stage.sv
module tconv_mul_stage
    import tconv_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [CH_W-1:0]           in_chan,
    input  logic [CODE_W-1:0]         in_code,
    input  coef_t                     coef,
    input  logic signed [TEMP_W-1:0]  deviation,
    output stage1_t                   s1,
    output logic [CH_W-1:0]           s1_chan
);

    logic [PROD_W-1:0] prod_c;

    always_comb begin
        prod_c = PROD_W'(in_code) * PROD_W'(coef.slope);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= '0;
            s1_chan <= '0;
        end else begin
            s1.valid <= in_valid;
            s1.zero  <= in_valid && (in_code == '0);
            s1.prod  <= in_valid ? prod_c : '0;
            s1.icpt  <= in_valid ? coef.icpt : '0;
            s1.dev   <= in_valid ? deviation : '0;
            s1_chan  <= in_valid ? in_chan : '0;
        end
    end

    p_stage_valid_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1.valid);

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (s1.zero == ($past(in_code) == '0)));

endmodule

// File: rtl/tconv_fin_stage.sv
module tconv_fin_stage
    import tconv_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  stage1_t                   s1,
    input  logic [CH_W-1:0]           s1_chan,
    output logic                      o_valid,
    output logic [CH_W-1:0]           o_chan,
    output logic signed [TEMP_W-1:0]  o_temp,
    output logic                      o_not_ready
);

    localparam int PAD_W = TEMP_W - PROD_W;

    logic [PROD_W-1:0]        quot;
    logic signed [TEMP_W-1:0] model;
    logic signed [TEMP_W-1:0] temp_c;

    always_comb begin
        // Product is non-negative, so unsigned division truncates toward zero
        quot   = s1.prod / PROD_W'(10);
        model  = s1.icpt - $signed({{PAD_W{1'b0}}, quot});
        temp_c = model + s1.dev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid     <= 1'b0;
            o_chan      <= '0;
            o_temp      <= '0;
            o_not_ready <= 1'b0;
        end else begin
            o_valid     <= s1.valid;
            o_chan      <= s1_chan;
            o_not_ready <= s1.valid && s1.zero;
            o_temp      <= (s1.valid && !s1.zero) ? temp_c : '0;
        end
    end

    p_out_follows_r1: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> o_valid);

    p_out_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !s1.valid |=> !o_valid);

    p_chan_carry_r8: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> (o_chan == $past(s1_chan)));

endmodule

// File: rtl/tconv_top.sv
module tconv_top
    import tconv_pkg::*;
#(
    parameter int CH_NUM = 4,
    localparam int CH_W  = (CH_NUM > 1) ? $clog2(CH_NUM) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [CH_W-1:0]           in_chan,
    input  logic [CODE_W-1:0]         in_code,
    input  logic                      cfg_mode,
    input  logic signed [TEMP_W-1:0]  cfg_offset,
    input  logic [SCALE_W-1:0]        cfg_scale,
    input  logic signed [TEMP_W-1:0]  cfg_deviation,
    output logic                      out_valid,
    output logic [CH_W-1:0]           out_chan,
    output logic signed [TEMP_W-1:0]  out_temp,
    output logic                      out_not_ready
);

    coef_t           coef;
    stage1_t         s1;
    logic [CH_W-1:0] s1_chan;
    conv_mode_e      mode;

    assign mode = conv_mode_e'(cfg_mode);

    tconv_coef_sel u_coef (
        .mode       (mode),
        .chan_is0   (in_chan == '0),
        .code       (in_code),
        .lin_offset (cfg_offset),
        .lin_scale  (cfg_scale),
        .coef       (coef)
    );

    tconv_mul_stage #(.CH_W(CH_W)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_code   (in_code),
        .coef      (coef),
        .deviation (cfg_deviation),
        .s1        (s1),
        .s1_chan   (s1_chan)
    );

    tconv_fin_stage #(.CH_W(CH_W)) u_fin (
        .clk         (clk),
        .rst         (rst),
        .s1          (s1),
        .s1_chan     (s1_chan),
        .o_valid     (out_valid),
        .o_chan      (out_chan),
        .o_temp      (out_temp),
        .o_not_ready (out_not_ready)
    );

    p_notready_blank_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_not_ready) |-> (out_temp == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_not_ready && out_temp == '0));

endmodule

// File: tb/tconv_top_bench.sv
`timescale 1ns/1ps
module tconv_top_bench;

    localparam int CH_W = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [CH_W-1:0]    in_chan = '0;
    logic [11:0]        in_code = '0;
    logic               cfg_mode = 1'b0;
    logic signed [31:0] cfg_offset = '0;
    logic [15:0]        cfg_scale = '0;
    logic signed [31:0] cfg_deviation = '0;
    logic               out_valid;
    logic [CH_W-1:0]    out_chan;
    logic signed [31:0] out_temp;
    logic               out_not_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int b_chan [8];
    int b_code [8];

    always #4 clk = ~clk;

    tconv_top u_tconv_top (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_chan       (in_chan),
        .in_code       (in_code),
        .cfg_mode      (cfg_mode),
        .cfg_offset    (cfg_offset),
        .cfg_scale     (cfg_scale),
        .cfg_deviation (cfg_deviation),
        .out_valid     (out_valid),
        .out_chan      (out_chan),
        .out_temp      (out_temp),
        .out_not_ready (out_not_ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_temp(input int chan, input int code);
        int t;
        if (code == 0) return 0;
        if (cfg_mode == 1'b0)
            t = int'(cfg_offset) - (code * int'(cfg_scale)) / 10;
        else if (code >= 1280)
            t = (-1191 * code) / 10 + 223000;
        else if (chan == 0)
            t = (-1452 * code) / 10 + 259000;
        else
            t = (-1590 * code) / 10 + 276000;
        return t + int'(cfg_deviation);
    endfunction

    // Streams b_chan/b_code[0..n-1] back to back; results checked two edges later
    task automatic run_batch(input string req, input int n);
        for (int i = 0; i <= n + 1; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R1", "out_valid", int'(out_valid), 1);
                chk("R8", "out_chan", int'(out_chan), b_chan[i-2]);
                chk("R4", "out_not_ready", int'(out_not_ready), (b_code[i-2] == 0) ? 1 : 0);
                chk(req, "out_temp", out_temp, exp_temp(b_chan[i-2], b_code[i-2]));
            end
            if (i < n) begin
                in_valid = 1'b1;
                in_chan  = CH_W'(b_chan[i]);
                in_code  = 12'(b_code[i]);
            end else begin
                in_valid = 1'b0;
                in_chan  = '0;
                in_code  = '0;
            end
        end
        @(negedge clk);
        chk("R1", "idle out_valid", int'(out_valid), 0);
        chk("R9", "idle out_temp", out_temp, 0);
        chk("R9", "idle out_not_ready", int'(out_not_ready), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9", "reset out_valid", int'(out_valid), 0);
        chk("R9", "reset out_temp", out_temp, 0);
        chk("R9", "reset out_not_ready", int'(out_not_ready), 0);
    endtask

    task automatic t_linear();
        cfg_mode = 1'b0; cfg_offset = 217000; cfg_scale = 1211; cfg_deviation = 0;
        b_chan[0] = 0; b_code[0] = 1955;
        b_chan[1] = 1; b_code[1] = 7;
        b_chan[2] = 2; b_code[2] = 4095;
        run_batch("R2", 3);
        cfg_offset = 100; cfg_scale = 3;     // 21/10 truncates to 2
        b_chan[0] = 3; b_code[0] = 7;
        b_chan[1] = 0; b_code[1] = 1;
        run_batch("R2", 2);
        cfg_offset = -5; cfg_scale = 16'hFFFF;
        b_chan[0] = 1; b_code[0] = 4095;
        run_batch("R2", 1);
    endtask

    task automatic t_deviation();
        cfg_mode = 1'b0; cfg_offset = 187744; cfg_scale = 672; cfg_deviation = 7000;
        b_chan[0] = 0; b_code[0] = 1503;
        b_chan[1] = 2; b_code[1] = 9;
        run_batch("R3", 2);
        cfg_mode = 1'b1; cfg_deviation = 8000;
        b_chan[0] = 1; b_code[0] = 1001;
        b_chan[1] = 0; b_code[1] = 1999;
        run_batch("R3", 2);
        cfg_deviation = -3;
        b_chan[0] = 0; b_code[0] = 3;
        run_batch("R3", 1);
    endtask

    task automatic t_zero();
        cfg_mode = 1'b0; cfg_offset = 217000; cfg_scale = 1211; cfg_deviation = 8000;
        b_chan[0] = 1; b_code[0] = 0;
        b_chan[1] = 2; b_code[1] = 800;
        b_chan[2] = 3; b_code[2] = 0;
        b_chan[3] = 0; b_code[3] = 1;
        run_batch("R4", 4);
        cfg_mode = 1'b1;
        b_chan[0] = 0; b_code[0] = 0;
        b_chan[1] = 3; b_code[1] = 0;
        run_batch("R4", 2);
    endtask

    task automatic t_knee();
        cfg_mode = 1'b1; cfg_offset = 0; cfg_scale = 0; cfg_deviation = 0;
        b_chan[0] = 0; b_code[0] = 1279;   // 0x4FF
        b_chan[1] = 0; b_code[1] = 1280;   // 0x500
        b_chan[2] = 3; b_code[2] = 1280;
        b_chan[3] = 2; b_code[3] = 4095;
        run_batch("R5", 4);
        b_chan[0] = 0; b_code[0] = 1;
        b_chan[1] = 0; b_code[1] = 777;
        run_batch("R6", 2);
    endtask

    task automatic t_chan();
        cfg_mode = 1'b1; cfg_offset = 0; cfg_scale = 0; cfg_deviation = 0;
        b_chan[0] = 1; b_code[0] = 1279;
        b_chan[1] = 2; b_code[1] = 768;
        b_chan[2] = 3; b_code[2] = 3;
        b_chan[3] = 0; b_code[3] = 768;
        run_batch("R7", 4);
    endtask

    task automatic t_stream();
        cfg_mode = 1'b0; cfg_offset = 251086; cfg_scale = 1130; cfg_deviation = 0;
        for (int i = 0; i < 8; i++) begin
            b_chan[i] = (i * 3) % 4;
            b_code[i] = 300 + i * 411;
        end
        run_batch("R1", 8);
    endtask

    task automatic t_ignore();
        cfg_mode = 1'b1; cfg_deviation = 0;
        cfg_offset = 32'sh7FFF0000; cfg_scale = 16'd9999;
        b_chan[0] = 0; b_code[0] = 1100;
        b_chan[1] = 2; b_code[1] = 2500;
        b_chan[2] = 1; b_code[2] = 401;
        run_batch("R10", 3);
        cfg_offset = -12345; cfg_scale = 1;
        run_batch("R10", 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_linear();
        t_deviation();
        t_zero();
        t_knee();
        t_chan();
        t_stream();
        t_ignore();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule